// File: doc/BRIEF.md
# Data-Dependent Sequential Multiplier

This block multiplies a 16-bit multiplicand by a 16-bit source operand and returns the full 32-bit product. It works through the source one bit position per step. Only positions that need an add or a subtract cost extra time, so the total time to finish depends on the bit pattern of the source. In unsigned mode every set bit of the source needs work. In signed mode the source is recoded with radix-2 Booth pairs, so only places where adjacent bits differ need work.

A pulse on `start` while the engine is idle captures both operands and the mode. `busy` then stays high until the finishing cycle. In that cycle `done` pulses for one clock, and the product and four condition flags update. The flags and the product then hold until the next operation finishes. The completion time is exact: it is a fixed overhead of 38 clocks plus two clocks for each source digit that needs work. A host can therefore rely on it cycle for cycle.

Top module: `iter_mul16`

## Requirements
- R1: With `mode_signed`=0, `prod` is the unsigned product of `mcand` and `src`. It is zero-extended and exact in 32 bits.
- R2: With `mode_signed`=1, `prod` is the 32-bit two's-complement product of the signed operands. The Booth digit for a bit pair (bit i, bit i-1), with bit -1 taken as 0, works as follows: 10 subtracts the shifted multiplicand, 01 adds it, and 00 or 11 only shift.
- R3: In unsigned mode, `done` rises exactly 38+2n rising edges after the edge that samples `start`, where n is the number of one bits in `src`.
- R4: In signed mode the same timing holds, with n being the number of adjacent pairs that differ in the 17-bit value {src, 1'b0}.
- R5: The worst case is 70 clocks. Unsigned reaches it with src=0xFFFF, and signed reaches it with src=0x5555. A source of 0 takes 38 clocks in both modes. In signed mode, 0xFFFF and 0x8000 each take 40 clocks.
- R6: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after the start is accepted through the cycle before `done`, and it is low in the `done` cycle.
- R7: A `start` while `busy` is high is ignored. The running operation keeps its operands, product and completion time, and no extra `done` follows.
- R8: In the `done` cycle, `flag_n` equals `prod[31]` and `flag_z` is 1 exactly when `prod` is zero. `flag_v` and `flag_c` are 0.
- R9: After reset, `busy`, `done`, `prod` and all flags are 0.
- R10: A `start` in the `done` cycle is accepted. That cycle still shows the earlier product, and the new operation then has its own full latency.
- R11: While idle, `prod` and the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode_signed | input | 1 | 1 = signed Booth mode, 0 = unsigned |
| mcand | input | 16 | Multiplicand |
| src | input | 16 | Source operand; its bits set the latency |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod | output | 32 | Product, updated with done |
| flag_n | output | 1 | Product sign |
| flag_z | output | 1 | Product is zero |
| flag_v | output | 1 | Overflow, always cleared |
| flag_c | output | 1 | Carry, always cleared |

## Verification
The completion pulse of one operation and the acceptance of the next `start` can fall in the same cycle, because `busy` has already dropped when `done` is high. The bench provokes this by raising `start` with new operands in the very cycle it observes `done`. In that cycle the product must still be the earlier one. The bench then counts the second operation's latency from that edge, checks it against 38+2n for the new source, and checks that the new product is correct. A separate scenario pulses `start` in the middle of a run. It checks that neither the finishing time nor the product of the running operation moves.

// File: rtl/iter_mul16.sv
module iter_mul16 #(
  parameter int BASE_CYCLES = 38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode_signed,
  input  logic [15:0] mcand,
  input  logic [15:0] src,
  output logic        busy,
  output logic        done,
  output logic [31:0] prod,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);
  localparam int DIGITS   = 16;
  localparam int TAIL_LEN = BASE_CYCLES - DIGITS;
  localparam int TW       = $clog2(TAIL_LEN);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_TAIL} st_t;

  st_t         st;
  logic [15:0] sr;
  logic        prev;
  logic        sgn;
  logic [31:0] mc;
  logic [31:0] acc;
  logic [3:0]  idx;
  logic [1:0]  ph;
  logic [TW-1:0] tcnt;

  wire accept = start && (st == S_IDLE);
  wire cur    = sr[0];
  wire do_add = sgn ? (~cur & prev) : cur;
  wire do_sub = sgn & cur & ~prev;
  wire nz     = do_add | do_sub;
  wire step   = !nz || (ph == 2'd2);

  assign busy   = (st != S_IDLE);
  assign flag_v = 1'b0;
  assign flag_c = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sr     <= '0;
      prev   <= 1'b0;
      sgn    <= 1'b0;
      mc     <= '0;
      acc    <= '0;
      idx    <= '0;
      ph     <= '0;
      tcnt   <= '0;
      done   <= 1'b0;
      prod   <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st   <= S_SCAN;
          sr   <= src;
          prev <= 1'b0;
          sgn  <= mode_signed;
          mc   <= mode_signed ? {{16{mcand[15]}}, mcand} : {16'h0, mcand};
          acc  <= '0;
          idx  <= '0;
          ph   <= '0;
        end
        S_SCAN: begin
          if (nz && ph == 2'd0)
            acc <= do_sub ? acc - mc : acc + mc;
          if (step) begin
            ph   <= '0;
            sr   <= sr >> 1;
            prev <= cur;
            mc   <= mc << 1;
            idx  <= idx + 4'd1;
            if (idx == 4'(DIGITS - 1)) begin
              st   <= S_TAIL;
              tcnt <= '0;
            end
          end else begin
            ph <= ph + 2'd1;
          end
        end
        S_TAIL: begin
          if (tcnt == TW'(TAIL_LEN - 1)) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            prod   <= acc;
            flag_n <= acc[31];
            flag_z <= (acc == 32'h0);
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] elapsed;
  logic [7:0] exp_lat;
  wire  [15:0] edges = src ^ {src[14:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      exp_lat <= '0;
    end else if (accept) begin
      elapsed <= '0;
      exp_lat <= 8'(BASE_CYCLES) + 8'(2 * (mode_signed ? $countones(edges) : $countones(src)));
    end else if (busy) begin
      elapsed <= elapsed + 8'd1;
    end
  end

  // R3 R4
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (elapsed == exp_lat));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done) && $stable(exp_lat) && $stable(sgn));

  // R8
  flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n == prod[31]) && (flag_z == (prod == 32'h0)) && !flag_v && !flag_c);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |=> (done || $stable(prod)));

  // R5
  worst_case_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (elapsed < 8'(BASE_CYCLES + 2 * DIGITS)));
endmodule

// File: tb/tb_iter_mul16.sv
module tb_iter_mul16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_signed = 1'b0;
  logic [15:0] mcand = '0;
  logic [15:0] src = '0;
  logic        busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] prod;

  int total = 0;
  int bad = 0;
  bit hung = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_mul16 dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_signed(mode_signed),
    .mcand(mcand), .src(src), .busy(busy), .done(done), .prod(prod),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic int exp_n(input bit sg, input logic [15:0] b);
    int n = 0;
    logic [16:0] x = {b, 1'b0};
    for (int i = 0; i < 16; i++)
      if (sg) n += (x[i+1] != x[i]) ? 1 : 0;
      else    n += b[i] ? 1 : 0;
    return n;
  endfunction

  function automatic logic [31:0] exp_prod(input bit sg, input logic [15:0] a, input logic [15:0] b);
    longint pa, pb;
    pa = sg ? longint'($signed(a)) : longint'(a);
    pb = sg ? longint'($signed(b)) : longint'(b);
    return 32'(pa * pb);
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic launch(input bit sg, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    start = 1'b1; mode_signed = sg; mcand = a; src = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits from the negedge right after the accepting edge; returns edge count
  task automatic wait_done(output int cyc, input bit poke_mid);
    int bsy_bad = 0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (!busy) bsy_bad++;
      if (poke_mid && cyc == 7) begin
        start = 1'b1; mode_signed = ~mode_signed; mcand = 16'h7777; src = 16'hFFFF;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (!done) hung = 1;
    check("R6 busy through run", bsy_bad == 0 && cyc > 0, bsy_bad, 0);
    check("R6 busy low at done", !busy, busy, 0);
  endtask

  task automatic verify(input string rq, input bit sg, input logic [15:0] a, input logic [15:0] b, input int cyc);
    logic [31:0] ep;
    int el;
    ep = exp_prod(sg, a, b);
    el = 38 + 2 * exp_n(sg, b);
    check(sg ? "R2 signed product" : "R1 unsigned product", prod == ep, prod, ep);
    check(sg ? {rq, " R4 signed latency"} : {rq, " R3 unsigned latency"}, cyc == el, cyc, el);
    check("R8 flags", flag_n == ep[31] && flag_z == (ep == 0) && !flag_v && !flag_c,
          {flag_n, flag_z, flag_v, flag_c}, {ep[31], ep == 0, 2'b00});
  endtask

  task automatic run_one(input string rq, input bit sg, input logic [15:0] a, input logic [15:0] b);
    int cyc;
    launch(sg, a, b);
    wait_done(cyc, 1'b0);
    verify(rq, sg, a, b, cyc);
    @(negedge clk);
    check("R6 done one cycle", !done, done, 0);
  endtask

  task automatic test_reset();
    check("R9 reset state", !busy && !done && prod == 0 && !flag_n && !flag_z && !flag_v && !flag_c,
          {busy, done, flag_n, flag_z, flag_v, flag_c}, 0);
    check("R9 reset prod", prod == 0, prod, 0);
  endtask

  task automatic test_corners();
    run_one("R5", 1'b0, 16'h0003, 16'h0000);
    run_one("R5", 1'b1, 16'h0003, 16'h0000);
    run_one("R5", 1'b0, 16'hFFFF, 16'hFFFF);
    run_one("R5", 1'b1, 16'h1234, 16'h5555);
    run_one("R5", 1'b1, 16'h8000, 16'hFFFF);
    run_one("R5", 1'b1, 16'h8000, 16'h8000);
    run_one("R5", 1'b0, 16'hFFFF, 16'h8000);
    run_one("R5", 1'b1, 16'h7FFF, 16'h8000);
    run_one("R5", 1'b1, 16'h0000, 16'h5555);
  endtask

  task automatic test_random();
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      run_one("R1", k[0], a, b);
    end
  endtask

  task automatic test_busy_start();
    int cyc;
    launch(1'b1, 16'hFF85, 16'h0F0F);
    wait_done(cyc, 1'b1);
    verify("R7", 1'b1, 16'hFF85, 16'h0F0F, cyc);
    @(negedge clk);
    check("R7 no extra done", !done && !busy, {done, busy}, 0);
  endtask

  task automatic test_back_to_back();
    int cyc;
    logic [31:0] first;
    launch(1'b0, 16'h1234, 16'h00F1);
    wait_done(cyc, 1'b0);
    first = exp_prod(1'b0, 16'h1234, 16'h00F1);
    check("R10 first product in done cycle", prod == first, prod, first);
    start = 1'b1; mode_signed = 1'b1; mcand = 16'hC001; src = 16'hA5A5;
    @(negedge clk);
    start = 1'b0;
    check("R10 new op busy", busy && !done, {busy, done}, 2'b10);
    wait_done(cyc, 1'b0);
    verify("R10", 1'b1, 16'hC001, 16'hA5A5, cyc);
  endtask

  task automatic test_idle_hold();
    logic [31:0] p;
    logic fn, fz;
    @(negedge clk);
    p = prod; fn = flag_n; fz = flag_z;
    mcand = 16'hAAAA; src = 16'h1111; mode_signed = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 idle hold", prod == p && flag_n == fn && flag_z == fz && !busy, prod, p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_corners();
    test_random();
    test_busy_start();
    test_back_to_back();
    test_idle_hold();
    if (hung) check("watchdog", 1'b0, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog", 1'b0, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule